// File: doc/BRIEF.md
# Setup-Frame Perfect Address Filter

This block holds a table of station addresses and decides, for each received frame, whether its destination address is wanted. The table is loaded from a special transmit buffer (a setup frame) that the transmit path hands to the block as a stream of 32-bit words instead of putting it on the wire. The setup frame is 192 bytes long, which is 48 words. Only the low 16 bits of each word carry address bytes, so three consecutive words form one 6-byte entry, and the table has 16 entries. Slots that the host leaves unused are filled with all-ones, so they match the broadcast address.

Receive words come from the receive data path. The first two words of a frame give the destination address. One cycle after the second word, the block gives a single accept or reject pulse. The address is compared against all entries in parallel. A pass-all-multicast control input also accepts any destination whose group bit is set. When the last setup word has been taken in, the whole table is replaced in one step. The block then reports completion with the success status word that the transmit path writes back to the descriptor.

Top module: `setup_addr_filter`

## Requirements
- R1: After reset, every table entry holds FF:FF:FF:FF:FF:FF. accept_o, reject_o and wb_valid_o are low, and wb_status_o is 0.
- R2: A setup frame is 48 words, and a word is taken in each cycle that setup_valid_i is high. Entry e is built from words 3e, 3e+1 and 3e+2. Word 3e+k supplies address byte 2k in bits [7:0] and address byte 2k+1 in bits [15:8]. Bits [31:16] of every setup word are ignored.
- R3: A received frame starts with a word that has rx_sof_i high. Destination byte n, for n from 0 to 3, is bits [8n+7:8n] of that word. Bytes 4 and 5 are bits [7:0] and [15:8] of the next valid word. Bits [31:16] of that second word are ignored.
- R4: When the destination equals any entry, accept_o pulses for exactly one cycle. The pulse comes in the cycle after the clock edge that sampled the second rx word.
- R5: When mc_pass_i is high in the cycle of the second rx word and bit 0 of destination byte 0 is 1, the frame is accepted even without a table match. When mc_pass_i is low, a group address is accepted only on a match.
- R6: A frame that is not accepted gives a one-cycle reject_o pulse in the same cycle where accept_o would have pulsed. Each frame gives exactly one of the two pulses, and accept_o and reject_o are never high together.
- R7: When the 48th setup word is sampled at edge N, wb_valid_o is high for the one cycle after edge N+1, with wb_status_o = 32'h7FFFFFFF. At all other times wb_status_o is 0.
- R8: The table changes only as a whole, at edge N+1 after the last setup word was sampled at edge N. A second rx word sampled at or before edge N+1 is judged against the old table, and one sampled later is judged against the new table. An unfinished setup frame leaves the table unchanged.
- R9: A setup word with setup_first_i high is always taken as word 0 of a new setup frame, whatever point the previous frame had reached.
- R10: After the decision, further rx words give no decision until the next word with rx_sof_i high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mc_pass_i | input | 1 | Accept every group-addressed frame |
| setup_valid_i | input | 1 | Setup word valid |
| setup_first_i | input | 1 | Setup word is word 0 of a setup frame |
| setup_word_i | input | 32 | Setup frame word |
| rx_valid_i | input | 1 | Receive word valid |
| rx_sof_i | input | 1 | Receive word is the first word of a frame |
| rx_word_i | input | 32 | Receive frame word |
| accept_o | output | 1 | One-cycle pulse: frame accepted |
| reject_o | output | 1 | One-cycle pulse: frame rejected |
| wb_valid_o | output | 1 | Setup frame consumed; status valid |
| wb_status_o | output | 32 | Descriptor status write-back value |

## Verification
On every cycle, the assertions check the following. The two decision pulses never coincide and never come back to back. A pulse only follows a sampled second rx word. The multicast pass forces an accept. The table stays the same except in the cycle after a commit. Completion pulses stay isolated. The bench scenarios are needed for the rest: the byte order in which setup words and rx words are unpacked, the matching against all 16 distinct entries, and the cycle-exact boundary where a frame's decision moves from the old table to the new one. The scenarios also cover an abandoned setup frame that must leave the table untouched.

// File: rtl/sf_filter_pkg.sv
package sf_filter_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned HALF_W = 16;
  localparam int unsigned ADDR_W = 48;
  localparam int unsigned PARTS  = ADDR_W / HALF_W;
  localparam logic [WORD_W-1:0] WB_OK = 32'h7FFF_FFFF;

  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_HALF = 2'd1,
    RX_DONE = 2'd2
  } rx_phase_e;
endpackage

// File: rtl/sf_table_loader.sv
module sf_table_loader
  import sf_filter_pkg::*;
#(
  parameter int unsigned N_ENT = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         valid_i,
  input  logic                         first_i,
  input  logic [WORD_W-1:0]            word_i,
  output logic [N_ENT-1:0][ADDR_W-1:0] table_o,
  output logic                         done_o
);
  localparam int unsigned EW = $clog2(N_ENT);

  logic [EW-1:0]                 ent_q, ent_cur;
  logic [1:0]                    part_q, part_cur;
  logic [N_ENT-1:0][ADDR_W-1:0]  shadow_q, table_q;
  logic                          commit_q, done_q, last_w;

  // setup_first_i restarts the frame at word 0
  assign ent_cur  = first_i ? '0 : ent_q;
  assign part_cur = first_i ? '0 : part_q;
  assign last_w   = valid_i && (ent_cur == EW'(N_ENT-1)) && (part_cur == 2'(PARTS-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ent_q    <= '0;
      part_q   <= '0;
      shadow_q <= '1;
      table_q  <= '1;
      commit_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      commit_q <= last_w;
      done_q   <= commit_q;
      if (commit_q) table_q <= shadow_q;
      if (valid_i) begin
        shadow_q[ent_cur][part_cur*HALF_W +: HALF_W] <= word_i[HALF_W-1:0];
        if (part_cur == 2'(PARTS-1)) begin
          part_q <= '0;
          ent_q  <= (ent_cur == EW'(N_ENT-1)) ? '0 : ent_cur + EW'(1);
        end else begin
          part_q <= part_cur + 2'd1;
          ent_q  <= ent_cur;
        end
      end
    end
  end

  assign table_o = table_q;
  assign done_o  = done_q;

  a_r2_part_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    part_q < 2'(PARTS));
  a_r8_table_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_q |=> $stable(table_q));
  a_r7_done_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
endmodule

// File: rtl/sf_addr_match.sv
module sf_addr_match
  import sf_filter_pkg::*;
#(
  parameter int unsigned N_ENT = 16
) (
  input  logic [N_ENT-1:0][ADDR_W-1:0] table_i,
  input  logic [ADDR_W-1:0]            da_i,
  output logic [N_ENT-1:0]             hit_o
);
  for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
    assign hit_o[g] = (table_i[g] == da_i);
  end
endmodule

// File: rtl/setup_addr_filter.sv
module setup_addr_filter
  import sf_filter_pkg::*;
#(
  parameter int unsigned N_ENT = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mc_pass_i,
  input  logic              setup_valid_i,
  input  logic              setup_first_i,
  input  logic [WORD_W-1:0] setup_word_i,
  input  logic              rx_valid_i,
  input  logic              rx_sof_i,
  input  logic [WORD_W-1:0] rx_word_i,
  output logic              accept_o,
  output logic              reject_o,
  output logic              wb_valid_o,
  output logic [WORD_W-1:0] wb_status_o
);
  logic [N_ENT-1:0][ADDR_W-1:0] table_w;
  logic [N_ENT-1:0]             hit_w;
  logic [ADDR_W-1:0]            da_w;
  logic [WORD_W-1:0]            lo_q;
  rx_phase_e                    phase_q;
  logic                         acc_q, rej_q, take_w, pass_w;

  sf_table_loader #(.N_ENT(N_ENT)) u_loader (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (setup_valid_i),
    .first_i (setup_first_i),
    .word_i  (setup_word_i),
    .table_o (table_w),
    .done_o  (wb_valid_o)
  );

  assign da_w = {rx_word_i[HALF_W-1:0], lo_q};

  sf_addr_match #(.N_ENT(N_ENT)) u_match (
    .table_i (table_w),
    .da_i    (da_w),
    .hit_o   (hit_w)
  );

  assign take_w = rx_valid_i && !rx_sof_i && (phase_q == RX_HALF);
  assign pass_w = (|hit_w) || (mc_pass_i && lo_q[0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q    <= '0;
      phase_q <= RX_IDLE;
      acc_q   <= 1'b0;
      rej_q   <= 1'b0;
    end else begin
      acc_q <= 1'b0;
      rej_q <= 1'b0;
      if (rx_valid_i && rx_sof_i) begin
        lo_q    <= rx_word_i;
        phase_q <= RX_HALF;
      end else if (take_w) begin
        acc_q   <= pass_w;
        rej_q   <= !pass_w;
        phase_q <= RX_DONE;
      end
    end
  end

  assign accept_o    = acc_q;
  assign reject_o    = rej_q;
  assign wb_status_o = wb_valid_o ? WB_OK : '0;

  a_r6_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(accept_o && reject_o));
  a_r6_after_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o || reject_o) |-> $past(rx_valid_i && !rx_sof_i));
  a_r10_no_repeat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o || reject_o) |=> !(accept_o || reject_o));
  a_r5_mc_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_w && mc_pass_i && lo_q[0]) |=> accept_o);
  a_r7_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> (wb_status_o == 32'h7FFF_FFFF));
endmodule

// File: tb/tb_setup_addr_filter.sv
module tb_setup_addr_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mc_pass = 1'b0;
  logic        su_valid = 1'b0, su_first = 1'b0;
  logic [31:0] su_word = '0;
  logic        rx_valid = 1'b0, rx_sof = 1'b0;
  logic [31:0] rx_word = '0;
  logic        accept, reject, wb_valid;
  logic [31:0] wb_status;

  always #10 clk = ~clk;

  setup_addr_filter dut (
    .clk_i(clk), .rst_ni(rst_n), .mc_pass_i(mc_pass),
    .setup_valid_i(su_valid), .setup_first_i(su_first), .setup_word_i(su_word),
    .rx_valid_i(rx_valid), .rx_sof_i(rx_sof), .rx_word_i(rx_word),
    .accept_o(accept), .reject_o(reject), .wb_valid_o(wb_valid), .wb_status_o(wb_status)
  );

  int    vectors = 0, fails = 0;
  bit    finished = 0;
  string cur_req = "R1";

  // behavioural reference: byte arrays, word index, pending commit
  logic [7:0]  m_act [96];
  logic [7:0]  m_frm [96];
  int          m_idx, m_phase;
  bit          m_pend;
  logic [31:0] m_lo;
  logic [7:0]  m_da [6];
  bit          e_acc, e_rej, e_wb, m_hit, m_eq;
  int          m_k;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 96; i++) begin m_act[i] = 8'hFF; m_frm[i] = 8'hFF; end
      m_idx = 0; m_phase = 0; m_pend = 0; m_lo = '0;
      e_acc = 0; e_rej = 0; e_wb = 0;
    end else begin
      e_acc = 0; e_rej = 0; e_wb = 0;
      if (rx_valid) begin
        if (rx_sof) begin
          m_lo = rx_word; m_phase = 1;
        end else if (m_phase == 1) begin
          for (int i = 0; i < 4; i++) m_da[i] = m_lo[8*i +: 8];
          m_da[4] = rx_word[7:0]; m_da[5] = rx_word[15:8];
          m_hit = 0;
          for (int e = 0; e < 16; e++) begin
            m_eq = 1;
            for (int i = 0; i < 6; i++) if (m_act[6*e+i] != m_da[i]) m_eq = 0;
            if (m_eq) m_hit = 1;
          end
          e_acc = m_hit || (mc_pass && m_da[0][0]);
          e_rej = !e_acc;
          m_phase = 2;
        end
      end
      if (m_pend) begin
        for (int i = 0; i < 96; i++) m_act[i] = m_frm[i];
        e_wb = 1; m_pend = 0;
      end
      if (su_valid) begin
        m_k = su_first ? 0 : m_idx;
        m_frm[2*m_k] = su_word[7:0]; m_frm[2*m_k+1] = su_word[15:8];
        if (m_k == 47) begin m_pend = 1; m_idx = 0; end
        else m_idx = m_k + 1;
      end
    end
  end

  always @(negedge clk) if (rst_n && !finished) begin
    vectors++;
    if (accept !== e_acc) begin fails++;
      $display("FAIL %s accept_o act=%0b exp=%0b t=%0t", cur_req, accept, e_acc, $time); end
    if (reject !== e_rej) begin fails++;
      $display("FAIL %s reject_o act=%0b exp=%0b t=%0t", cur_req, reject, e_rej, $time); end
    if (wb_valid !== e_wb) begin fails++;
      $display("FAIL R7 wb_valid_o act=%0b exp=%0b t=%0t", wb_valid, e_wb, $time); end
    if (wb_status !== (e_wb ? 32'h7FFFFFFF : 32'h0)) begin fails++;
      $display("FAIL R7 wb_status_o act=%h exp=%h", wb_status, e_wb ? 32'h7FFFFFFF : 32'h0); end
  end

  function automatic logic [47:0] mk_addr(int seed, int e);
    logic [7:0] b0 = 8'h02 | 8'(e << 4);
    return {8'(8'h50 + seed), 8'(8'h40 + e), 8'h30, 8'(8'hC0 ^ seed), 8'(8'h10 + e), b0};
  endfunction

  // setup word n of a table, upper half is junk (R2)
  function automatic logic [31:0] su_w(int seed, int n);
    logic [47:0] a = mk_addr(seed, n / 3);
    return {16'(16'hDEAD ^ n), a[16*(n%3) +: 16]};
  endfunction

  task automatic put_setup(logic [31:0] w, bit first);
    su_valid = 1; su_first = first; su_word = w;
    @(negedge clk);
    su_valid = 0; su_first = 0;
  endtask

  task automatic load_table(int seed);
    for (int n = 0; n < 48; n++) put_setup(su_w(seed, n), n == 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic send_rx(logic [47:0] da, logic [15:0] junk, int extra);
    rx_valid = 1; rx_sof = 1; rx_word = da[31:0];
    @(negedge clk);
    rx_sof = 0; rx_word = {junk, da[47:32]};
    @(negedge clk);
    for (int i = 0; i < extra; i++) begin rx_word = 32'hA5A5_0000 + i; @(negedge clk); end
    rx_valid = 0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired act=running exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    vectors++;
    if (accept || reject || wb_valid || wb_status != 0) begin fails++;
      $display("FAIL R1 outputs in reset act=%b%b%b exp=000", accept, reject, wb_valid); end
    rst_n = 1;
    @(negedge clk);
    cur_req = "R1";
    send_rx(48'hFFFF_FFFF_FFFF, 16'h0, 0);
    send_rx(mk_addr(1, 0), 16'h0, 0);

    cur_req = "R2";
    load_table(1);
    cur_req = "R4";
    for (int e = 0; e < 16; e++) send_rx(mk_addr(1, e), 16'h0, 0);
    cur_req = "R6";
    send_rx(mk_addr(2, 3), 16'h0, 0);
    send_rx(mk_addr(1, 3) ^ 48'h0100_0000_0000, 16'h0, 0);
    send_rx(48'hFFFF_FFFF_FFFF, 16'h0, 0);
    cur_req = "R3";
    send_rx(mk_addr(1, 5), 16'hBEEF, 0);

    cur_req = "R5";
    mc_pass = 1;
    send_rx(48'h0000_5E00_0001, 16'h0, 0);
    send_rx(48'h0000_5E00_0002, 16'h0, 0);
    mc_pass = 0;
    send_rx(48'h0000_5E00_0001, 16'h0, 0);

    cur_req = "R10";
    send_rx(mk_addr(1, 7), 16'h0, 3);
    rx_valid = 1; rx_word = mk_addr(1, 7)[47:32]; @(negedge clk); rx_valid = 0;
    @(negedge clk);

    cur_req = "R8";
    for (int n = 0; n < 20; n++) put_setup(su_w(2, n), n == 0);
    repeat (3) @(negedge clk);
    send_rx(mk_addr(1, 2), 16'h0, 0);
    send_rx(mk_addr(2, 2), 16'h0, 0);

    cur_req = "R9";
    for (int n = 0; n < 47; n++) put_setup(su_w(3, n), n == 0);
    su_valid = 1; su_word = su_w(3, 47);
    rx_valid = 1; rx_sof = 1; rx_word = mk_addr(1, 0)[31:0];
    @(negedge clk);
    su_valid = 0; rx_sof = 0; rx_word = {16'h0, mk_addr(1, 0)[47:32]};
    @(negedge clk);
    rx_sof = 1; rx_word = mk_addr(1, 0)[31:0];
    @(negedge clk);
    rx_sof = 0; rx_word = {16'h0, mk_addr(1, 0)[47:32]};
    @(negedge clk);
    rx_valid = 0;
    repeat (2) @(negedge clk);
    send_rx(mk_addr(3, 0), 16'h0, 0);
    send_rx(mk_addr(3, 15), 16'h0, 0);
    send_rx(mk_addr(1, 15), 16'h0, 0);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule